// File: doc/BRIEF.md
# Split-Write Settings Register Bank

This block sits on a narrow memory-mapped control bus with a 16-bit data path and byte addresses, and turns pairs of 16-bit bus writes into single 32-bit configuration updates. Software writes the low half of a setting first and the high half second; the high-half write releases one strobe carrying the register index and the assembled 32-bit word to the configuration logic downstream.

The bank has no storage that software can read back. Reads inside its window are acknowledged and return zero. The bank owns an address span of four bytes per register, starting at the base of slave window 8 (slave windows are 128 bytes, selected by the address bits from bit 7 up). With the default 64 registers the span is 256 bytes, 0x400 to 0x4FF, which also covers slave window 9. Register n lives at base + 4·n. Address bit 1 selects the half, and address bit 0 is ignored.

Top module: `cfg_settings_bank`

## Requirements
- R1: While rstN is low and in the first cycle after reset, busAck and cfgStb are 0, cfgIdx and cfgData are 0, and the staged low half is 0.
- R2: A bus cycle whose address bits [10:8] are not 4 (outside 0x400 to 0x4FF) gets no acknowledge, fires no strobe and leaves the staged low half unchanged.
- R3: Every cycle with busStb high and an address inside the window, read or write, gives busAck high in exactly the following cycle.
- R4: busRdData is always zero.
- R5: A write inside the window with address bit 1 equal to 0 stores busWrData as the staged low half and fires no strobe.
- R6: A write inside the window with address bit 1 equal to 1 raises cfgStb for exactly the next cycle, with cfgIdx equal to address bits [7:2] and cfgData equal to {busWrData, staged low half}.
- R7: The staged low half is shared by all indices and persists: a high-half write with no fresh low-half write before it uses whatever low half is staged, and repeated high-half writes reuse it.
- R8: Reads inside the window fire no strobe and leave the staged low half unchanged.
- R9: Address bit 0 has no effect on decode, half selection or index.
- R10: Between strobes cfgIdx and cfgData keep the values of the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busStb | input | 1 | Bus cycle request, one cycle per access |
| busWe | input | 1 | 1 for write, 0 for read |
| busAddr | input | 11 | Byte address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, always zero |
| busAck | output | 1 | Acknowledge, one cycle after an in-window request |
| cfgStb | output | 1 | One-cycle configuration update strobe |
| cfgIdx | output | 6 | Register index of the update |
| cfgData | output | 32 | Assembled 32-bit value of the update |

## Verification
The bench builds the bank with its defaults: an 11-bit address, 16-bit halves, 64 registers and slave window 8. That puts the first and last register (index 0 at 0x400, index 63 at 0x4FC) and the addresses just below and just above the span within a handful of writes, so the bench aims at both window edges, at both halves of the edge registers, and at a high-half write right after reset with nothing staged. A random sweep over a range that straddles both window edges then mixes reads, writes and back-to-back requests.

// File: rtl/cfg_settings_pkg.sv
package cfg_settings_pkg;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic loadLow;   // stage the low half
    logic fireHigh;  // assemble and emit the update
  } bankCtrlT;

endpackage

// File: rtl/cfg_settings_ctrl.sv
module cfg_settings_ctrl
  import cfg_settings_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SPAN_W    = 8,
  parameter int BASE_ADDR = 1024
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busStb,
  input  logic                     busWe,
  input  logic [ADDR_W-1:SPAN_W]   addrTag,
  input  logic                     halfSel,
  output bankCtrlT                 ctrl,
  output logic                     busAck
);

  localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-SPAN_W-1:0] WIN_TAG = BASE_VEC[ADDR_W-1:SPAN_W];

  logic hit;
  logic ackQ;

  assign hit = busStb && (addrTag == WIN_TAG);

  always_comb begin
    ctrl          = '0;
    ctrl.loadLow  = hit && busWe && !halfSel;
    ctrl.fireHigh = hit && busWe && halfSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= hit;
  end

  assign busAck = ackQ;

endmodule

// File: rtl/cfg_settings_dp.sv
module cfg_settings_dp
  import cfg_settings_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankCtrlT              ctrl,
  input  logic [IDX_W-1:0]      wrIdx,
  input  logic [HALF_W-1:0]     wrData,
  output logic                  cfgStb,
  output logic [IDX_W-1:0]      cfgIdx,
  output logic [2*HALF_W-1:0]   cfgData
);

  logic [HALF_W-1:0]   lowQ;
  logic                stbQ;
  logic [IDX_W-1:0]    idxQ;
  logic [2*HALF_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ <= '0;
    end else if (ctrl.loadLow) begin
      lowQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbQ  <= 1'b0;
      idxQ  <= '0;
      dataQ <= '0;
    end else begin
      stbQ <= ctrl.fireHigh;
      if (ctrl.fireHigh) begin
        idxQ  <= wrIdx;
        dataQ <= {wrData, lowQ};
      end
    end
  end

  assign cfgStb  = stbQ;
  assign cfgIdx  = idxQ;
  assign cfgData = dataQ;

endmodule

// File: rtl/cfg_settings_bank.sv
module cfg_settings_bank
  import cfg_settings_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int HALF_W    = 16,
  parameter int NUM_REGS  = 64,
  parameter int SLAVE_LSB = 7,
  parameter int SLAVE_ID  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busStb,
  input  logic                           busWe,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [HALF_W-1:0]              busWrData,
  output logic [HALF_W-1:0]              busRdData,
  output logic                           busAck,
  output logic                           cfgStb,
  output logic [$clog2(NUM_REGS)-1:0]    cfgIdx,
  output logic [2*HALF_W-1:0]            cfgData
);

  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int SPAN_W    = IDX_W + 2;
  localparam int BASE_ADDR = SLAVE_ID << SLAVE_LSB;

  bankCtrlT ctrl;
  logic     unusedByteLane;

  assign unusedByteLane = busAddr[0];
  assign busRdData      = '0;

  cfg_settings_ctrl #(
    .ADDR_W   (ADDR_W),
    .SPAN_W   (SPAN_W),
    .BASE_ADDR(BASE_ADDR)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busStb (busStb),
    .busWe  (busWe),
    .addrTag(busAddr[ADDR_W-1:SPAN_W]),
    .halfSel(busAddr[1]),
    .ctrl   (ctrl),
    .busAck (busAck)
  );

  cfg_settings_dp #(
    .HALF_W(HALF_W),
    .IDX_W (IDX_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .wrIdx  (busAddr[SPAN_W-1:2]),
    .wrData (busWrData),
    .cfgStb (cfgStb),
    .cfgIdx (cfgIdx),
    .cfgData(cfgData)
  );

endmodule

// File: rtl/cfg_settings_bank_chk.sv
module cfg_settings_bank_chk #(
  parameter int ADDR_W    = 11,
  parameter int HALF_W    = 16,
  parameter int NUM_REGS  = 64,
  parameter int SLAVE_LSB = 7,
  parameter int SLAVE_ID  = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           busStb,
  input logic                           busWe,
  input logic [ADDR_W-1:0]              busAddr,
  input logic [HALF_W-1:0]              busWrData,
  input logic [HALF_W-1:0]              busRdData,
  input logic                           busAck,
  input logic                           cfgStb,
  input logic [$clog2(NUM_REGS)-1:0]    cfgIdx,
  input logic [2*HALF_W-1:0]            cfgData
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int SPAN_W = IDX_W + 2;
  localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(SLAVE_ID << SLAVE_LSB);

  logic inWin, lowWr, highWr;
  logic [HALF_W-1:0] shadowLow;

  assign inWin  = busStb && (busAddr[ADDR_W-1:SPAN_W] == BASE_VEC[ADDR_W-1:SPAN_W]);
  assign lowWr  = inWin && busWe && !busAddr[1];
  assign highWr = inWin && busWe && busAddr[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      shadowLow <= '0;
    else if (lowWr) shadowLow <= busWrData;
  end

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> busAck); // R3

  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> !busAck); // R2

  AST_HIGH_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    highWr |=> (cfgStb && cfgIdx == $past(busAddr[SPAN_W-1:2])
                && cfgData[2*HALF_W-1:HALF_W] == $past(busWrData))); // R6

  AST_LOW_FROM_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    highWr |=> cfgData[HALF_W-1:0] == $past(shadowLow)); // R7

  AST_NO_STRAY_STB: assert property (@(posedge clk) disable iff (!rstN)
    !highWr |=> !cfgStb); // R8

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !highWr |=> ($stable(cfgIdx) && $stable(cfgData))); // R10

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> busRdData == '0); // R4

endmodule

bind cfg_settings_bank cfg_settings_bank_chk #(
  .ADDR_W   (ADDR_W),
  .HALF_W   (HALF_W),
  .NUM_REGS (NUM_REGS),
  .SLAVE_LSB(SLAVE_LSB),
  .SLAVE_ID (SLAVE_ID)
) uChk (.*);

// File: tb/tb_cfg_settings_bank.sv
`timescale 1ns/1ps
module tb_cfg_settings_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busStb = 1'b0;
  logic        busWe = 1'b0;
  logic [10:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        busAck;
  logic        cfgStb;
  logic [5:0]  cfgIdx;
  logic [31:0] cfgData;

  always #2 clk = ~clk;  // 250 MHz

  cfg_settings_bank dut (
    .clk(clk), .rstN(rstN), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busAck(busAck), .cfgStb(cfgStb), .cfgIdx(cfgIdx), .cfgData(cfgData)
  );

  int    vecs = 0;
  int    bad  = 0;
  string curReq = "R1";

  // behavioural reference state
  logic        mAck = 1'b0;
  logic        mStb = 1'b0;
  logic [5:0]  mIdx = '0;
  logic [31:0] mData = '0;
  logic [15:0] mLow = '0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R3", "busAck", {31'b0, busAck}, {31'b0, mAck});
    chk("R4", "busRdData", {16'b0, busRdData}, 32'h0);
    chk(curReq, "cfgStb", {31'b0, cfgStb}, {31'b0, mStb});
    chk(curReq, "cfgIdx", {26'b0, cfgIdx}, {26'b0, mIdx});
    chk(curReq, "cfgData", cfgData, mData);
  endtask

  // called at a falling edge: compare, drive, advance one cycle
  task automatic step(input logic s, input logic w,
                      input logic [10:0] a, input logic [15:0] d);
    logic hit;
    compareAll();
    busStb = s; busWe = w; busAddr = a; busWrData = d;
    @(posedge clk);
    hit  = s && (a >= 11'h400) && (a <= 11'h4FF);
    mAck = hit;
    mStb = hit && w && (a % 4 >= 2);
    if (mStb) begin
      mIdx  = 6'((a - 11'h400) / 4);
      mData = {d, mLow};
    end
    if (hit && w && (a % 4 < 2)) mLow = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 11'h0, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    compareAll();                       // during reset
    rstN = 1'b1;
    compareAll();                       // first cycle after release
    // R1/R7: high half with nothing staged gives a zero low half
    curReq = "R7";
    step(1'b1, 1'b1, 11'h416, 16'hABCD);  // idx 5, high
    idle(1);

    curReq = "R6";                        // full pair, idx 3
    step(1'b1, 1'b1, 11'h40C, 16'h1234);
    step(1'b1, 1'b1, 11'h40E, 16'h5678);
    idle(2);                               // R10 hold

    curReq = "R5";                        // low only: no strobe
    step(1'b1, 1'b1, 11'h420, 16'hBEEF);
    idle(2);

    curReq = "R7";                        // high on other idx reuses staged
    step(1'b1, 1'b1, 11'h426, 16'hC001);
    step(1'b1, 1'b1, 11'h42A, 16'hC002);
    idle(1);

    curReq = "R8";                        // reads: no strobe, staging kept
    step(1'b1, 1'b0, 11'h400, 16'hFFFF);
    step(1'b1, 1'b0, 11'h402, 16'hFFFF);
    step(1'b1, 1'b1, 11'h43E, 16'h0F0F);
    idle(1);

    curReq = "R2";                        // outside the window
    step(1'b1, 1'b1, 11'h3FC, 16'h1111);
    step(1'b1, 1'b1, 11'h3FE, 16'h2222);
    step(1'b1, 1'b1, 11'h500, 16'h3333);
    step(1'b1, 1'b1, 11'h502, 16'h4444);
    step(1'b1, 1'b0, 11'h000, 16'h0);
    step(1'b1, 1'b1, 11'h402, 16'h5555);   // idx 0 shows staging untouched
    idle(1);

    curReq = "R9";                        // byte lane bit ignored, edge idx
    step(1'b1, 1'b1, 11'h4FD, 16'h6060);
    step(1'b1, 1'b1, 11'h4FF, 16'h7070);   // idx 63
    step(1'b1, 1'b1, 11'h401, 16'h8181);
    step(1'b1, 1'b1, 11'h403, 16'h9191);   // idx 0
    idle(1);

    curReq = "R3";                        // back-to-back requests
    step(1'b1, 1'b0, 11'h480, 16'h0);
    step(1'b1, 1'b1, 11'h482, 16'hA0A0);
    step(1'b1, 1'b1, 11'h486, 16'hA1A1);
    step(1'b1, 1'b1, 11'h488, 16'hA2A2);
    step(1'b1, 1'b1, 11'h48A, 16'hA3A3);
    idle(2);

    curReq = "R10";                       // random sweep across both edges
    for (int i = 0; i < 400; i++) begin
      logic [10:0] a;
      a = 11'h3C0 + 11'($urandom_range(0, 383));
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           a, 16'($urandom));
    end
    idle(2);
    compareAll();

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule